// File: doc/BRIEF.md
# Set/Clear GPIO Bank Controller

This block controls 32 general-purpose pins split into two banks of 16. Software reaches it through a plain register port: a write strobe, a read strobe, a byte address and a 32-bit data word. Each control register is never stored directly. A write carries a set mask in its lower 16 bits and a clear mask in its upper 16 bits, so one pin can change with a single write and no read-modify-write is needed.

The control registers hold, per pin, the output value, the output enable, the input enable, two output auxiliary selects and one input auxiliary select. Pad inputs pass through a two-flop synchronizer. The synchronized level can be read back, is passed to an auxiliary consumer when selected, and feeds rising-edge and falling-edge flag registers. Software clears these flags by writing ones. A parameter holds a pin-availability mask, and unavailable pins stay inert.

A pin is used as plain GPIO by clearing its three auxiliary selects. For an output, both enables are set. For an input only, the input enable is set and the output enable is cleared.

Top module: `sc_gpio_bank`

## Requirements
- R1: In a write to a control register of a bank, a one in data bit n (n = 0..15) sets pin n of that bank. Pins whose set and clear bits are both zero keep their value.
- R2: A one in data bit n+16 clears pin n of the addressed bank. If the set bit and the clear bit of one pin are both one, the pin is cleared.
- R3: Address bit 7 selects the bank: 0 for pins 0..15 and 1 for pins 16..31. The register offsets within a bank are output value 0x00, output enable 0x04, input enable 0x08, output aux 1 select 0x0C, output aux 2 select 0x10, input aux select 0x14, synchronized level 0x18, rising flags 0x1C and falling flags 0x20.
- R4: A read strobe returns the addressed register's 16 pin bits of that bank in data bits 15:0, with bits 31:16 zero. The data is valid on the cycle after the strobe.
- R5: A change on a pad input appears in the level register and on the aux input port after the second rising clock edge.
- R6: A rising (falling) transition of the synchronized level sets that pin's rising (falling) flag one edge later, but only while its input enable is set.
- R7: Writing to a flag register clears each flag whose data bit 15:0 is one and keeps flags written with zero. An edge detected in the same cycle as the clear keeps its flag set.
- R8: Pins outside the mask AVAIL_MASK (default 0x0F7FFFFF, which excludes pins 23 and 28..31) read as zero in every register, ignore writes, never raise flags and never enable their pad.
- R9: padOe equals the output enable bit. padOut is auxDrv1 when output aux 1 select is set, otherwise auxDrv2 when output aux 2 select is set, otherwise the output value bit.
- R10: auxIn of a pin is its synchronized level when its input aux select is set, and zero otherwise.
- R11: After reset every register is zero, so no pad is enabled and no flag is set.
- R12: A write to an offset above 0x20 changes nothing, and a read of such an offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 8 | Byte address: bit 7 selects the bank, bits 6:2 select the register |
| regWdata | input | 32 | Write data: set mask in 15:0, clear mask in 31:16 |
| regRdata | output | 32 | Read data, valid one cycle after regRd |
| padIn | input | 32 | Asynchronous pad input levels |
| auxDrv1 | input | 32 | Auxiliary output source 1 |
| auxDrv2 | input | 32 | Auxiliary output source 2 |
| padOut | output | 32 | Pad output value |
| padOe | output | 32 | Pad output enable |
| auxIn | output | 32 | Synchronized input routed to the auxiliary consumer |

## Verification
A control write takes effect at the clock edge that captures it, so padOut and padOe are checked at the falling edge right after that write. Read data registers at the edge after the strobe. The scoreboard monitor compares it at the next falling edge, one cycle after the driver queued the expected word. Pad inputs need two edges to reach auxIn and the level register, and a third edge to set a flag. The bench checks auxIn at one and at two falling edges after a change, and it places a flag-clear write so that it is captured at exactly the edge that latches a new falling edge.

// File: rtl/sc_gpio_pkg.sv
package sc_gpio_pkg;
  localparam int BANK_W   = 16;
  localparam int DATA_W   = 2 * BANK_W;
  localparam int NUM_CTL  = 6;
  localparam int WIN_BITS = 7;

  typedef enum logic [3:0] {
    RG_OUTVAL = 4'd0,
    RG_OUTEN  = 4'd1,
    RG_INEN   = 4'd2,
    RG_OAUX1  = 4'd3,
    RG_OAUX2  = 4'd4,
    RG_IAUX1  = 4'd5,
    RG_LEVEL  = 4'd6,
    RG_RISE   = 4'd7,
    RG_FALL   = 4'd8,
    RG_NONE   = 4'd15
  } regSel_e;

  typedef struct packed {
    logic              ctlWr;
    regSel_e           ctlSel;
    logic              riseClr;
    logic              fallClr;
    logic              rdEn;
    regSel_e           rdSel;
    logic [3:0]        bank;
    logic [BANK_W-1:0] setBits;
    logic [BANK_W-1:0] clrBits;
  } strobe_t;
endpackage

// File: rtl/sc_gpio_ctrl.sv
module sc_gpio_ctrl
  import sc_gpio_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output strobe_t           stb
);
  localparam int BANK_IDX_W = ADDR_W - WIN_BITS;

  logic [4:0]            regIdx;
  logic [BANK_IDX_W-1:0] bankIdx;
  logic                  bankOk;
  logic                  idxOk;
  regSel_e               sel;

  always_comb begin
    regIdx  = regAddr[WIN_BITS-1:2];
    bankIdx = regAddr[ADDR_W-1:WIN_BITS];
    bankOk  = (32'(bankIdx) < NUM_BANKS);
    idxOk   = (regIdx <= 5'(RG_FALL));
    sel     = (bankOk && idxOk) ? regSel_e'(regIdx[3:0]) : RG_NONE;

    stb         = '0;
    stb.ctlSel  = sel;
    stb.rdSel   = sel;
    stb.bank    = 4'(bankIdx);
    stb.setBits = regWdata[BANK_W-1:0];
    stb.clrBits = regWdata[DATA_W-1:BANK_W];
    stb.ctlWr   = regWr && (32'(sel) < NUM_CTL);
    stb.riseClr = regWr && (sel == RG_RISE);
    stb.fallClr = regWr && (sel == RG_FALL);
    stb.rdEn    = regRd;
  end
endmodule

// File: rtl/sc_gpio_dp.sv
module sc_gpio_dp
  import sc_gpio_pkg::*;
#(
  parameter int              NUM_BANKS  = 2,
  parameter int              PINS       = NUM_BANKS * BANK_W,
  parameter logic [PINS-1:0] AVAIL_MASK = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [PINS-1:0]   padIn,
  input  logic [PINS-1:0]   auxDrv1,
  input  logic [PINS-1:0]   auxDrv2,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   auxIn,
  output logic [DATA_W-1:0] rdData
);
  logic [NUM_CTL-1:0][PINS-1:0] ctl;
  logic [NUM_CTL-1:0]           hit;
  logic [PINS-1:0] sync1, sync2, sync3;
  logic [PINS-1:0] riseFlag, fallFlag;
  logic [PINS-1:0] setFull, clrFull;
  logic [PINS-1:0] riseNew, fallNew;
  logic [PINS-1:0] riseClrVec, fallClrVec;
  logic [PINS-1:0] rdVec, rdShift;
  int              bankShift;

  always_comb begin
    bankShift  = BANK_W * int'(stb.bank);
    setFull    = PINS'(stb.setBits) << bankShift;
    clrFull    = PINS'(stb.clrBits) << bankShift;
    riseClrVec = stb.riseClr ? setFull : '0;
    fallClrVec = stb.fallClr ? setFull : '0;
    riseNew    = sync2 & ~sync3 & ctl[RG_INEN];
    fallNew    = ~sync2 & sync3 & ctl[RG_INEN];
    for (int c = 0; c < NUM_CTL; c++)
      hit[c] = stb.ctlWr && (stb.ctlSel == regSel_e'(4'(c)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctl   <= '0;
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      for (int c = 0; c < NUM_CTL; c++)
        if (hit[c]) ctl[c] <= (ctl[c] | setFull) & ~clrFull & AVAIL_MASK;
      sync1 <= padIn & AVAIL_MASK;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      riseFlag <= '0;
      fallFlag <= '0;
    end else begin
      riseFlag <= (riseFlag & ~riseClrVec) | riseNew;
      fallFlag <= (fallFlag & ~fallClrVec) | fallNew;
    end
  end

  always_comb begin
    case (stb.rdSel)
      RG_OUTVAL: rdVec = ctl[RG_OUTVAL];
      RG_OUTEN:  rdVec = ctl[RG_OUTEN];
      RG_INEN:   rdVec = ctl[RG_INEN];
      RG_OAUX1:  rdVec = ctl[RG_OAUX1];
      RG_OAUX2:  rdVec = ctl[RG_OAUX2];
      RG_IAUX1:  rdVec = ctl[RG_IAUX1];
      RG_LEVEL:  rdVec = sync2;
      RG_RISE:   rdVec = riseFlag;
      RG_FALL:   rdVec = fallFlag;
      default:   rdVec = '0;
    endcase
    rdShift = rdVec >> bankShift;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (stb.rdEn) rdData <= {{(DATA_W-BANK_W){1'b0}}, rdShift[BANK_W-1:0]};
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pad
    assign padOe[p]  = ctl[RG_OUTEN][p];
    assign padOut[p] = ctl[RG_OAUX1][p] ? auxDrv1[p]
                     : ctl[RG_OAUX2][p] ? auxDrv2[p]
                     : ctl[RG_OUTVAL][p];
    assign auxIn[p]  = sync2[p] & ctl[RG_IAUX1][p];
  end

  for (genvar c = 0; c < NUM_CTL; c++) begin : g_chk
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
      hit[c] |=> ((ctl[c] & $past(clrFull)) == '0)); // R2
    AST_SET_APPLIES: assert property (@(posedge clk) disable iff (!rstN)
      hit[c] |=> ((ctl[c] & $past(setFull & ~clrFull & AVAIL_MASK))
                  == $past(setFull & ~clrFull & AVAIL_MASK))); // R1
    AST_UNTOUCHED_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (((ctl[c] ^ $past(ctl[c])) & ~$past(hit[c] ? (setFull | clrFull) : '0)) == '0)); // R1
  end

  AST_EDGE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((riseFlag | fallFlag) & ~$past(riseFlag | fallFlag) & ~$past(ctl[RG_INEN])) == '0)); // R6
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(riseFlag) & ~riseFlag & ~$past(riseClrVec)) == '0)
          && (($past(fallFlag) & ~fallFlag & ~$past(fallClrVec)) == '0)); // R7
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe | riseFlag | fallFlag | auxIn) & ~AVAIL_MASK) == '0); // R8
endmodule

// File: rtl/sc_gpio_bank.sv
module sc_gpio_bank
  import sc_gpio_pkg::*;
#(
  parameter int                                NUM_BANKS  = 2,
  parameter logic [NUM_BANKS*BANK_W-1:0]       AVAIL_MASK = 32'h0F7F_FFFF
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWr,
  input  logic                          regRd,
  input  logic [7:0]                    regAddr,
  input  logic [DATA_W-1:0]             regWdata,
  output logic [DATA_W-1:0]             regRdata,
  input  logic [NUM_BANKS*BANK_W-1:0]   padIn,
  input  logic [NUM_BANKS*BANK_W-1:0]   auxDrv1,
  input  logic [NUM_BANKS*BANK_W-1:0]   auxDrv2,
  output logic [NUM_BANKS*BANK_W-1:0]   padOut,
  output logic [NUM_BANKS*BANK_W-1:0]   padOe,
  output logic [NUM_BANKS*BANK_W-1:0]   auxIn
);
  localparam int PINS = NUM_BANKS * BANK_W;

  strobe_t stb;

  sc_gpio_ctrl #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (8)
  ) ctrl_i (
    .regWr    (regWr),
    .regRd    (regRd),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .stb      (stb)
  );

  sc_gpio_dp #(
    .NUM_BANKS  (NUM_BANKS),
    .PINS       (PINS),
    .AVAIL_MASK (AVAIL_MASK)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .padIn   (padIn),
    .auxDrv1 (auxDrv1),
    .auxDrv2 (auxDrv2),
    .padOut  (padOut),
    .padOe   (padOe),
    .auxIn   (auxIn),
    .rdData  (regRdata)
  );
endmodule

// File: tb/sc_gpio_bank_tb_top.sv
`timescale 1ns/1ps
module sc_gpio_bank_tb_top;
  localparam logic [7:0] A_OUTVAL = 8'h00, A_OUTEN = 8'h04, A_INEN = 8'h08;
  localparam logic [7:0] A_OAUX1 = 8'h0C, A_OAUX2 = 8'h10, A_IAUX1 = 8'h14;
  localparam logic [7:0] A_LEVEL = 8'h18, A_RISE = 8'h1C, A_FALL = 8'h20;
  localparam logic [7:0] A_BAD = 8'h24, HI = 8'h80;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] padIn = '0, auxDrv1 = '0, auxDrv2 = '1;
  logic [31:0] padOut, padOe, auxIn;
  logic        rdSeen = 1'b0;
  int          checks = 0;
  int          failures = 0;
  item_t       sbq[$];

  always #4 clk = ~clk;

  sc_gpio_bank dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .padIn(padIn), .auxDrv1(auxDrv1),
    .auxDrv2(auxDrv2), .padOut(padOut), .padOe(padOe), .auxIn(auxIn)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // caller stands at a falling edge; strobe is captured at the next rising edge
  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdExp(input logic [7:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    sbq.push_back(it);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) rdSeen <= regRd;

  always @(negedge clk) begin
    if (rdSeen) begin
      if (sbq.size() == 0) begin
        checks++; failures++;
        $display("FAIL R4 actual=%08h expected=queued item", regRdata);
      end else begin
        item_t it;
        it = sbq.pop_front();
        chk(regRdata, it.exp, it.tag);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R11 reset state
    chk(padOe, 32'h0, "R11 padOe after reset");
    chk(padOut, 32'h0, "R11 padOut after reset");
    chk(auxIn, 32'h0, "R11 auxIn after reset");
    rdExp(A_OUTVAL, 32'h0, "R11 outval reset");
    rdExp(HI | A_RISE, 32'h0, "R11 rise flags reset");

    // R1 R2 R4 set/clear semantics
    wrReg(A_OUTVAL, 32'h0000_00A5);
    rdExp(A_OUTVAL, 32'h0000_00A5, "R1 set bits");
    wrReg(A_OUTVAL, 32'h0005_0000);
    rdExp(A_OUTVAL, 32'h0000_00A0, "R2 clear bits");
    wrReg(A_OUTVAL, 32'h0082_0082);
    rdExp(A_OUTVAL, 32'h0000_0020, "R2 clear wins");

    // R3 R8 high bank and reserved pins
    wrReg(HI | A_OUTVAL, 32'h0000_FFFF);
    rdExp(HI | A_OUTVAL, 32'h0000_0F7F, "R8 reserved ignore writes");
    rdExp(A_OUTVAL, 32'h0000_0020, "R3 low bank untouched");

    // R12 unknown offset
    wrReg(A_BAD, 32'h0000_FFFF);
    rdExp(A_BAD, 32'h0, "R12 unknown read zero");
    rdExp(A_OUTEN, 32'h0, "R12 unknown write no effect");

    // R9 pad mux
    wrReg(A_OUTEN, 32'h0000_0021);
    chk(padOe, 32'h0000_0021, "R9 padOe follows enable");
    chk(padOut & 32'h21, 32'h20, "R9 padOut from outval");
    wrReg(A_OAUX2, 32'h0000_0001);
    chk(padOut & 32'h1, 32'h1, "R9 aux2 drives pad");
    wrReg(A_OAUX1, 32'h0000_0001);
    chk(padOut & 32'h1, 32'h0, "R9 aux1 has priority");
    wrReg(A_OAUX1, 32'h0001_0000);
    wrReg(A_OAUX2, 32'h0001_0000);
    chk(padOut & 32'h21, 32'h20, "R9 back to outval");
    wrReg(HI | A_OUTEN, 32'h0000_FFFF);
    chk(padOe, 32'h0F7F_0021, "R8 reserved pad never enabled");

    // R5 R10 R6 input path
    wrReg(A_INEN, 32'h0000_00EF);
    wrReg(A_IAUX1, 32'h0000_0008);
    idle(3);
    padIn[3] = 1'b1;
    @(negedge clk);
    chk(auxIn & 32'h8, 32'h0, "R5 one edge not yet");
    @(negedge clk);
    chk(auxIn & 32'h8, 32'h8, "R10 aux in after two edges");
    @(negedge clk);
    rdExp(A_RISE, 32'h0000_0008, "R6 rise flag");
    padIn[4] = 1'b1;
    idle(4);
    rdExp(A_RISE, 32'h0000_0008, "R6 no flag without input enable");
    rdExp(A_LEVEL, 32'h0000_0018, "R5 level readback");

    // R7 write one to clear
    wrReg(A_RISE, 32'h0000_0008);
    rdExp(A_RISE, 32'h0, "R7 clear rise flag");
    padIn[3] = 1'b0;
    repeat (2) @(negedge clk);
    wrReg(A_FALL, 32'h0000_0008);
    rdExp(A_FALL, 32'h0000_0008, "R7 same-cycle edge survives");
    wrReg(A_FALL, 32'h0);
    rdExp(A_FALL, 32'h0000_0008, "R7 zero bits keep flag");
    wrReg(A_FALL, 32'h0000_0008);
    rdExp(A_FALL, 32'h0, "R7 fall flag cleared");

    // R8 R3 high bank inputs
    wrReg(HI | A_INEN, 32'h0000_FFFF);
    idle(2);
    padIn[23] = 1'b1;
    padIn[16] = 1'b1;
    idle(4);
    rdExp(HI | A_RISE, 32'h0000_0001, "R8 reserved pin no flag");
    rdExp(HI | A_LEVEL, 32'h0000_0001, "R3 high bank level");

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule